// File: doc/BRIEF.md
# Flat-Table I/O Address Translator

This block sits between a multimedia DMA master and the memory system and turns the master's virtual addresses into physical ones. The translation lives in memory as one linear array of 32-bit words, one word per 4 KiB page, holding the physical page number for that page. Software programs a window of virtual pages (a first page and a page count minus one), the physical page at which the table starts, and two fallback pages. Accesses that land outside the window, or on a page whose table word is zero, are steered to the read fallback page or to the write fallback page, depending on direction. No fault is raised.

A request arrives on a valid/ready port, and the translated address leaves on a second valid/ready port. Only one translation is in progress at a time. A four-entry, fully associative cache of recent translations answers repeated pages without touching memory. On a miss the block issues a single one-word read on a table-fetch port and waits for the returned word. Writing any value to the update register empties the cache. Translation can be switched off, and a bypass mode forwards addresses unchanged.

Top module: `iova_xlate`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and tbl_req_valid are 0. Register reads return 0 for config (offset 0x04), 0x0000FFFF for the window span (offset 0x20), and 0x00000100 for the version register (offset 0x00, version code 1 in bits 15:8).
- R2: Translation is off when config bit 0 (enable) is 0 or config bit 4 (bypass) is 1. In that state rsp_addr equals req_addr and no table read is issued.
- R3: For a window page with no cached translation, the block issues one table read at tbl_base_ppn*4096 + (vpn - win_base_vpn)*4. Here vpn is req_addr[31:12], tbl_base_ppn is at offset 0x10 and win_base_vpn is at offset 0x1c. The response is {entry[19:0], req_addr[11:0]}. The table address is held stable until tbl_req_ready.
- R4: A page is out of the window when vpn < win_base_vpn or vpn - win_base_vpn > span (offset 0x20). Such a page answers with the read fallback page (offset 0x14) for reads, or the write fallback page (offset 0x18) for writes (req_write=1), joined to the page offset. No table read is issued.
- R5: A fetched table word of zero answers with the fallback page for the access direction and is not cached: the next access to that page fetches again.
- R6: An access to a cached page issues no table read, and rsp_valid rises in the cycle after the request is accepted.
- R7: The cache holds 4 translations and fills slots in round-robin order starting at slot 0. After five distinct pages have been cached, the first one is fetched again while the second still hits.
- R8: Any write to the update register (offset 0x08) invalidates every cached translation.
- R9: An update-register write while a table read is outstanding still lets the fetched translation be returned, but it is not cached.
- R10: req_ready stays 0 from acceptance until the response handshake. While rsp_ready is 0, rsp_valid stays 1 and rsp_addr stays stable.
- R11: cfg_rdata returns the addressed register one cycle after cfg_re. Config keeps only bits 0, 1 (clock gate enable, stored) and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid one cycle after cfg_re |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Translated address valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Physical address |
| tbl_req_valid | output | 1 | Table word read request |
| tbl_req_ready | input | 1 | Memory accepts the table read |
| tbl_req_addr | output | 32 | Byte address of the table word |
| tbl_rsp_valid | input | 1 | Table word returned |
| tbl_rsp_data | input | 32 | Table word |

## Verification
The bench targets the window edges. It tests the page just below the first page and the page just past the last page, where an off-by-one compare would fetch instead of redirecting. It also tests the last valid page, whose table address would come out wrong with a bad offset scale. Zero table words are sent for both reads and writes, to catch a design that caches an unmapped page or picks the wrong fallback. Five distinct pages check that the victim slot is the oldest and not a still-live entry. An invalidation timed while a fetch is outstanding exposes a design that caches stale data.

// File: rtl/iova_xlate_pkg.sv
package iova_xlate_pkg;

  localparam int unsigned REG_OFF_W = 6;

  typedef enum logic [REG_OFF_W-1:0] {
    REG_VERSION  = 6'h00,
    REG_CONFIG   = 6'h04,
    REG_UPDATE   = 6'h08,
    REG_AUTH     = 6'h0c,
    REG_TBL_BASE = 6'h10,
    REG_DEF_RD   = 6'h14,
    REG_DEF_WR   = 6'h18,
    REG_WIN_BASE = 6'h1c,
    REG_WIN_SPAN = 6'h20
  } reg_off_e;

  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_GATE_BIT = 1;
  localparam int unsigned CFG_BYP_BIT  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TREQ,
    ST_TWAIT,
    ST_RESP
  } xl_state_e;

endpackage

// File: rtl/iova_xlate_regs.sv
module iova_xlate_regs
  import iova_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W           = 32,
  parameter int unsigned PAGE_SHIFT       = 12,
  parameter int unsigned VERSION          = 1,
  parameter int unsigned DEF_WINDOW_PAGES = 65536
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic                         cfg_re,
  input  logic [REG_OFF_W-1:0]         cfg_addr,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  output logic                         xl_en,
  output logic                         xl_bypass,
  output logic                         flush,
  output logic [ADDR_W-PAGE_SHIFT-1:0] tbl_base_ppn,
  output logic [ADDR_W-PAGE_SHIFT-1:0] def_rd_ppn,
  output logic [ADDR_W-PAGE_SHIFT-1:0] def_wr_ppn,
  output logic [ADDR_W-PAGE_SHIFT-1:0] win_base_vpn,
  output logic [ADDR_W-PAGE_SHIFT-1:0] win_span
);
  localparam int unsigned PN_W = ADDR_W - PAGE_SHIFT;
  localparam logic [PN_W-1:0] SPAN_RST = PN_W'(DEF_WINDOW_PAGES - 1);

  logic        en_q, gate_q, byp_q;
  logic [31:0] auth_q;

  assign flush        = cfg_we && (cfg_addr == REG_UPDATE);
  assign xl_en        = en_q;
  assign xl_bypass    = byp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; gate_q <= 1'b0; byp_q <= 1'b0;
      auth_q <= '0;
      tbl_base_ppn <= '0; def_rd_ppn <= '0; def_wr_ppn <= '0;
      win_base_vpn <= '0; win_span <= SPAN_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_CONFIG: begin
          en_q   <= cfg_wdata[CFG_EN_BIT];
          gate_q <= cfg_wdata[CFG_GATE_BIT];
          byp_q  <= cfg_wdata[CFG_BYP_BIT];
        end
        REG_AUTH:     auth_q       <= cfg_wdata;
        REG_TBL_BASE: tbl_base_ppn <= cfg_wdata[PN_W-1:0];
        REG_DEF_RD:   def_rd_ppn   <= cfg_wdata[PN_W-1:0];
        REG_DEF_WR:   def_wr_ppn   <= cfg_wdata[PN_W-1:0];
        REG_WIN_BASE: win_base_vpn <= cfg_wdata[PN_W-1:0];
        REG_WIN_SPAN: win_span     <= cfg_wdata[PN_W-1:0];
        default: ;
      endcase
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      REG_VERSION: rd_mux[15:8] = 8'(VERSION);
      REG_CONFIG: begin
        rd_mux[CFG_EN_BIT]   = en_q;
        rd_mux[CFG_GATE_BIT] = gate_q;
        rd_mux[CFG_BYP_BIT]  = byp_q;
      end
      REG_AUTH:     rd_mux = auth_q;
      REG_TBL_BASE: rd_mux = 32'(tbl_base_ppn);
      REG_DEF_RD:   rd_mux = 32'(def_rd_ppn);
      REG_DEF_WR:   rd_mux = 32'(def_wr_ppn);
      REG_WIN_BASE: rd_mux = 32'(win_base_vpn);
      REG_WIN_SPAN: rd_mux = 32'(win_span);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_mux;
  end

  // R11: a config write reads back with only its three defined bits
  p_cfg_mask_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == REG_CONFIG) |=>
      (en_q == $past(cfg_wdata[CFG_EN_BIT])) && (byp_q == $past(cfg_wdata[CFG_BYP_BIT])));

endmodule

// File: rtl/iova_xlate_tlb.sv
module iova_xlate_tlb #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lkp_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [PTR_W-1:0]   victim_q;
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_way
    assign hit_vec[i] = valid_q[i] && (vpn_q[i] == lkp_vpn);

    always_ff @(posedge clk) begin
      if (rst || flush)
        valid_q[i] <= 1'b0;
      else if (ins_en && victim_q == PTR_W'(i))
        valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (ins_en && !flush && victim_q == PTR_W'(i)) begin
        vpn_q[i] <= ins_vpn;
        ppn_q[i] <= ins_ppn;
      end
    end
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst)
      victim_q <= '0;
    else if (ins_en && !flush)
      victim_q <= (victim_q == PTR_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
  end

  // R7: a page is never held in two slots
  p_hit_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R8: an invalidation leaves no live slot behind
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W           = 32,
  parameter int unsigned PAGE_SHIFT       = 12,
  parameter int unsigned TLB_ENTRIES      = 4,
  parameter int unsigned VERSION          = 1,
  parameter int unsigned DEF_WINDOW_PAGES = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [5:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              tbl_req_valid,
  input  logic              tbl_req_ready,
  output logic [ADDR_W-1:0] tbl_req_addr,
  input  logic              tbl_rsp_valid,
  input  logic [31:0]       tbl_rsp_data
);
  localparam int unsigned PN_W = ADDR_W - PAGE_SHIFT;

  logic            xl_en, xl_bypass, flush;
  logic [PN_W-1:0] tbl_base_ppn, def_rd_ppn, def_wr_ppn, win_base_vpn, win_span;

  iova_xlate_regs #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .VERSION(VERSION), .DEF_WINDOW_PAGES(DEF_WINDOW_PAGES)
  ) u_regs (
    .clk, .rst, .cfg_we, .cfg_re, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .xl_en, .xl_bypass, .flush,
    .tbl_base_ppn, .def_rd_ppn, .def_wr_ppn, .win_base_vpn, .win_span
  );

  xl_state_e             state_q;
  logic                  wr_q, discard_q;
  logic [PAGE_SHIFT-1:0] off_q;
  logic [PN_W-1:0]       vpn_q;

  logic [PN_W-1:0]       vpn_in, rel_in, dflt_in, dflt_q, hit_ppn;
  logic [PAGE_SHIFT-1:0] off_in;
  logic                  in_win, hit, accept, passthru, ins_en, entry_zero;

  assign vpn_in   = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign off_in   = req_addr[PAGE_SHIFT-1:0];
  assign rel_in   = vpn_in - win_base_vpn;
  assign in_win   = (vpn_in >= win_base_vpn) && (rel_in <= win_span);
  assign dflt_in  = req_write ? def_wr_ppn : def_rd_ppn;
  assign dflt_q   = wr_q ? def_wr_ppn : def_rd_ppn;
  assign accept   = req_valid && req_ready;
  assign passthru = !xl_en || xl_bypass;

  assign entry_zero = (tbl_rsp_data == '0);
  assign ins_en = (state_q == ST_TWAIT) && tbl_rsp_valid && !entry_zero
                  && !discard_q && !flush;

  iova_xlate_tlb #(
    .ENTRIES(TLB_ENTRIES), .VPN_W(PN_W), .PPN_W(PN_W)
  ) u_tlb (
    .clk, .rst, .flush,
    .lkp_vpn(vpn_in), .hit, .hit_ppn,
    .ins_en, .ins_vpn(vpn_q), .ins_ppn(tbl_rsp_data[PN_W-1:0])
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign tbl_req_valid = (state_q == ST_TREQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      wr_q         <= 1'b0;
      discard_q    <= 1'b0;
      off_q        <= '0;
      vpn_q        <= '0;
      rsp_addr     <= '0;
      tbl_req_addr <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          wr_q  <= req_write;
          off_q <= off_in;
          vpn_q <= vpn_in;
          if (passthru) begin
            rsp_addr <= req_addr;
            state_q  <= ST_RESP;
          end else if (!in_win) begin
            rsp_addr <= {dflt_in, off_in};
            state_q  <= ST_RESP;
          end else if (hit) begin
            rsp_addr <= {hit_ppn, off_in};
            state_q  <= ST_RESP;
          end else begin
            tbl_req_addr <= {tbl_base_ppn, {PAGE_SHIFT{1'b0}}}
                            + (ADDR_W'(rel_in) << 2);
            discard_q    <= 1'b0;
            state_q      <= ST_TREQ;
          end
        end
        ST_TREQ: begin
          if (flush) discard_q <= 1'b1;
          if (tbl_req_ready) state_q <= ST_TWAIT;
        end
        ST_TWAIT: begin
          if (flush) discard_q <= 1'b1;
          if (tbl_rsp_valid) begin
            rsp_addr <= entry_zero ? {dflt_q, off_q}
                                   : {tbl_rsp_data[PN_W-1:0], off_q};
            state_q  <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: response held until taken
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)));

  // R10: nothing new accepted while a fetch is pending
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    tbl_req_valid |-> !req_ready);

  // R3: table read held until accepted
  p_treq_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tbl_req_valid && !tbl_req_ready) |=> (tbl_req_valid && $stable(tbl_req_addr)));

  // R2: untranslated path answers next cycle with the request address
  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && passthru) |=> (rsp_valid && rsp_addr == $past(req_addr)));

  // R4: out-of-window access never reads the table
  p_outwin_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !passthru && !in_win) |=> (rsp_valid && !tbl_req_valid));

endmodule

// File: tb/iova_xlate_test.sv
module iova_xlate_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        tbl_req_valid;
  logic        tbl_req_ready = 1'b1;
  logic [31:0] tbl_req_addr;
  logic        tbl_rsp_valid = 1'b0;
  logic [31:0] tbl_rsp_data = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  iova_xlate uut (
    .clk, .rst, .cfg_we, .cfg_re, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .req_valid, .req_ready, .req_addr, .req_write,
    .rsp_valid, .rsp_ready, .rsp_addr,
    .tbl_req_valid, .tbl_req_ready, .tbl_req_addr,
    .tbl_rsp_valid, .tbl_rsp_data
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_re = 1'b0;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  // One translation; the task plays the memory side of the table port.
  task automatic xact(input logic wr, input logic [31:0] a, input logic [31:0] ent,
                      input logic xf, input logic [31:0] xta, input logic [31:0] xres,
                      input logic flush_mid, input string tag);
    logic fetched = 1'b0, got = 1'b0, send = 1'b0;
    logic [31:0] ta = '0, res = '0;
    int lat = -1;
    @(negedge clk);
    chk(req_ready, {tag, " idle"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b0;
      tbl_rsp_valid = 1'b0;
      if (send) begin tbl_rsp_valid = 1'b1; tbl_rsp_data = ent; send = 1'b0; end
      if (tbl_req_valid && tbl_req_ready) begin
        fetched = 1'b1; ta = tbl_req_addr; send = 1'b1;
        if (flush_mid) begin cfg_we = 1'b1; cfg_addr = 6'h08; cfg_wdata = '0; end
      end
      if (rsp_valid) begin got = 1'b1; res = rsp_addr; lat = c; end
    end
    chk(got, {tag, " response"}, 32'(got), 32'd1);
    chk(fetched == xf, {tag, " fetch"}, 32'(fetched), 32'(xf));
    if (xf) chk(ta == xta, {tag, " table addr"}, ta, xta);
    if (!xf) chk(lat == 0, {tag, " latency"}, 32'(lat), 32'd0);
    chk(res == xres, {tag, " result"}, res, xres);
  endtask

  // {wr, addr, table word, expect fetch, expect table addr, expect result}
  // window: first vpn 0x100, 16 pages, table at 0x80000, fallbacks 0x0DEAD / 0x0BEEF
  localparam int NV = 12;
  localparam logic [129:0] VEC [NV] = '{
    {1'b0, 32'h0010_0ABC, 32'h0001_2345, 1'b1, 32'h0008_0000, 32'h1234_5ABC}, // R3 first page
    {1'b0, 32'h0010_0FFF, 32'h0,         1'b0, 32'h0,         32'h1234_5FFF}, // R6 hit
    {1'b1, 32'h0010_F004, 32'h0000_0777, 1'b1, 32'h0008_003C, 32'h0077_7004}, // R3 last page
    {1'b0, 32'h000F_F123, 32'h0,         1'b0, 32'h0,         32'h0DEA_D123}, // R4 below
    {1'b1, 32'h0011_0010, 32'h0,         1'b0, 32'h0,         32'h0BEE_F010}, // R4 above
    {1'b0, 32'h0010_5020, 32'h0,         1'b1, 32'h0008_0014, 32'h0DEA_D020}, // R5 zero read
    {1'b1, 32'h0010_5030, 32'h0,         1'b1, 32'h0008_0014, 32'h0BEE_F030}, // R5 zero write
    {1'b0, 32'h0010_1000, 32'h0000_0011, 1'b1, 32'h0008_0004, 32'h0001_1000}, // R7 slot 2
    {1'b0, 32'h0010_2000, 32'h0000_0022, 1'b1, 32'h0008_0008, 32'h0002_2000}, // R7 slot 3
    {1'b0, 32'h0010_3000, 32'h0000_0033, 1'b1, 32'h0008_000C, 32'h0003_3000}, // R7 evicts slot 0
    {1'b0, 32'h0010_F008, 32'h0,         1'b0, 32'h0,         32'h0077_7008}, // R7 slot 1 live
    {1'b0, 32'h0010_0000, 32'h0001_2346, 1'b1, 32'h0008_0000, 32'h1234_6000}  // R7 evicted refetch
  };
  localparam int VTAG [NV] = '{3, 6, 3, 4, 4, 5, 5, 7, 7, 7, 7, 7};

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(tbl_req_valid == 1'b0, "R1 tbl_req_valid", 32'(tbl_req_valid), 32'd0);
    cfg_read(6'h04, 32'h0, "R1 config");
    cfg_read(6'h20, 32'h0000_FFFF, "R1 span");
    cfg_read(6'h00, 32'h0000_0100, "R1 version");

    // R11: readback and config masking
    cfg_write(6'h04, 32'hFFFF_FFFF);
    cfg_read(6'h04, 32'h0000_0013, "R11 config mask");
    cfg_write(6'h0c, 32'hA5A5_0F0F);
    cfg_read(6'h0c, 32'hA5A5_0F0F, "R11 auth");

    cfg_write(6'h10, 32'h0000_0080);
    cfg_write(6'h1c, 32'h0000_0100);
    cfg_write(6'h20, 32'h0000_000F);
    cfg_write(6'h14, 32'h0000_DEAD);
    cfg_write(6'h18, 32'h0000_BEEF);
    cfg_write(6'h04, 32'h0000_0003);
    cfg_read(6'h1c, 32'h0000_0100, "R11 window base");

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i][129], VEC[i][128:97], VEC[i][96:65], VEC[i][64],
           VEC[i][63:32], VEC[i][31:0], 1'b0, $sformatf("R%0d vec%0d", VTAG[i], i));
    end

    // R10: stalled consumer on a cached page (0x103)
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0010_3ABC; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid, "R10 rsp held", 32'(rsp_valid), 32'd1);
      chk(rsp_addr == 32'h0003_3ABC, "R10 rsp stable", rsp_addr, 32'h0003_3ABC);
      chk(!req_ready, "R10 busy", 32'(req_ready), 32'd0);
      if (k == 2) rsp_ready = 1'b1;
      @(negedge clk);
    end
    chk(!rsp_valid && req_ready, "R10 released", 32'({rsp_valid, req_ready}), 32'b01);

    // R8: invalidation forces a refetch of a cached page
    cfg_write(6'h08, 32'h0);
    xact(1'b0, 32'h0010_3000, 32'h0000_0033, 1'b1, 32'h0008_000C, 32'h0003_3000, 1'b0, "R8 refetch");

    // R9: invalidation during a fetch discards the fill
    xact(1'b0, 32'h0010_4000, 32'h0000_0044, 1'b1, 32'h0008_0010, 32'h0004_4000, 1'b1, "R9 in flight");
    xact(1'b0, 32'h0010_4000, 32'h0000_0044, 1'b1, 32'h0008_0010, 32'h0004_4000, 1'b0, "R9 not cached");

    // R2: disabled and bypass
    cfg_write(6'h04, 32'h0000_0000);
    xact(1'b0, 32'h0010_0ABC, 32'h0, 1'b0, 32'h0, 32'h0010_0ABC, 1'b0, "R2 disabled");
    cfg_write(6'h04, 32'h0000_0011);
    xact(1'b1, 32'h00AB_C123, 32'h0, 1'b0, 32'h0, 32'h00AB_C123, 1'b0, "R2 bypass");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule